// File: doc/BRIEF.md
# USB OUT Endpoint Receive Controller

This block is the device-side receive path for one USB OUT endpoint. It sits behind a packet-level front end that has already decoded tokens and stripped CRC and bit stuffing. For each OUT token it decides whether to take the data packet that follows or to answer NAK. Accepted bytes go into a receive FIFO as data entries. The programmed packet count is decremented once per acknowledged packet.

When the count reaches zero, the block queues a completion entry in the FIFO directly behind the last payload byte. Software drains the FIFO through a pop port. The transfer-done flag is raised and the endpoint disabled only when that completion entry is popped, so software has already read every byte of the transfer when it sees completion.

Sticky event flags are cleared by writing ones. A single interrupt line combines the flags that are set and enabled.

Top module: `usb_out_ep_rx`

## Requirements
- R1: A token seen while the endpoint is disabled or its packet count is zero stores no data. It is answered by `hs_nak`, high for one cycle, in the cycle after `rx_end`.
- R2: A token is accepted only if the free FIFO space, counted in words including uncommitted ones, is at least MPS+1. Otherwise the packet is answered with NAK and no data is stored.
- R3: The bytes of an accepted packet become readable at `rd_word` only in the cycle after `rx_end`. Each byte forms one entry with bit 8 = 0 and bits 7:0 = the byte, in arrival order.
- R4: A successful packet produces a one-cycle `hs_ack` in the cycle after `rx_end`. In that same cycle `pcnt` is lower by exactly 1 and flag bit 0 (packet acknowledged) is set.
- R5: When a packet brings the count to zero, a completion entry becomes readable two cycles after `rx_end`, behind that packet's data. The entry has bit 8 = 1, bits 7:4 = EP_NUM and bits 3:0 = 3.
- R6: Popping the completion entry sets flag bit 1 (transfer done) and clears `ep_enabled` at the same clock edge. Popping data entries does neither.
- R7: A packet with more than MPS bytes is dropped. All its bytes are removed from the FIFO, neither `hs_ack` nor `hs_nak` is issued, `pcnt` is unchanged, and flag bit 2 (oversize) is set.
- R8: Flags are sticky. A one in `flag_clr` clears the matching bit. If a set and a clear meet in the same cycle, the set wins.
- R9: `irq` is high exactly when some flag bit and its `irq_en` bit are both one.
- R10: A one-cycle `cfg_load` enables the endpoint and loads `cfg_pcnt` into `pcnt`. A previously disabled endpoint accepts packets again after this.
- R11: A pop while the FIFO holds no readable entry has no effect on the FIFO contents or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_out | input | 1 | OUT token for this endpoint (one cycle) |
| rx_valid | input | 1 | Payload byte strobe |
| rx_byte | input | 8 | Payload byte |
| rx_end | input | 1 | End of data packet (one cycle, after the last byte) |
| hs_ack | output | 1 | Send ACK handshake |
| hs_nak | output | 1 | Send NAK handshake |
| cfg_load | input | 1 | Enable endpoint and load packet count |
| cfg_pcnt | input | PCNT_W | Packet count to load |
| pop | input | 1 | Remove head FIFO entry |
| rd_valid | output | 1 | FIFO head entry is readable |
| rd_word | output | 9 | Head entry: bit 8 tag, bits 7:0 payload |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| irq_en | input | 3 | Per-flag interrupt enable |
| flags | output | 3 | Bit 0 acknowledged, bit 1 transfer done, bit 2 oversize |
| irq | output | 1 | Interrupt request |
| ep_enabled | output | 1 | Endpoint enable state |
| pcnt | output | PCNT_W | Remaining packet count |

## Verification
A behavioural model built from queues is compared with every output on every clock.

The stimulus covers several packet patterns:
- Full-size, short and zero-length packets within one transfer. These separate the count and completion handling from the byte storage.
- Back-to-back packets without popping. These fill the FIFO until the space threshold refuses a token. A single pop then frees exactly enough room to admit the next packet, which pins down the MPS+1 rule.
- Oversize, disabled-endpoint and zero-count packets. These show the three ways a token is refused or dropped.
- Pops on an empty FIFO and a final one-packet transfer after re-enable. These check the completion timing.

// File: rtl/usbo_pkg.sv
package usbo_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RX   = 2'd1,
        ST_DROP = 2'd2,
        ST_STS  = 2'd3
    } rx_state_e;

    localparam logic [3:0] STS_XFER_DONE = 4'd3;
    localparam int         WORD_W        = 9;
endpackage

// File: rtl/usbo_rx_fifo.sv
module usbo_rx_fifo #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              commit,
    input  logic              rollback,
    input  logic              pop,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word,
    output logic [$clog2(DEPTH):0] free_cnt
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] cm;
        logic [AW:0] rd;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WORD_W-1:0] mem [DEPTH];
    logic [AW:0] used;

    assign used     = ptr_q.wr - ptr_q.rd;
    assign free_cnt = (AW+1)'(DEPTH) - used;
    assign rd_valid = ptr_q.cm != ptr_q.rd;
    assign rd_word  = mem[ptr_q.rd[AW-1:0]];

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en)            ptr_d.wr = ptr_q.wr + 1'b1;
        if (rollback)         ptr_d.wr = ptr_q.cm;
        if (commit)           ptr_d.cm = ptr_d.wr;
        if (pop && rd_valid)  ptr_d.rd = ptr_q.rd + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[ptr_q.wr[AW-1:0]] <= wr_word;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> used < (AW+1)'(DEPTH)); // R2
    AST_ROLLBACK_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> ptr_q.cm == $past(ptr_q.cm)); // R7
endmodule

// File: rtl/usbo_flags.sv
module usbo_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] irq_en,
    output logic [N-1:0] flags,
    output logic         irq
);
    logic [N-1:0] flg_d, flg_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb flg_d[i] = set[i] | (flg_q[i] & ~clr[i]);

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flg_q[i] && !clr[i]) |=> flg_q[i]); // R8
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;
    assign irq   = |(flg_q & irq_en);
endmodule

// File: rtl/usbo_ep_ctrl.sv
module usbo_ep_ctrl
    import usbo_pkg::*;
#(
    parameter int MPS    = 4,
    parameter int DEPTH  = 16,
    parameter int EP_NUM = 1,
    parameter int PCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_out,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_end,
    input  logic              cfg_load,
    input  logic [PCNT_W-1:0] cfg_pcnt,
    input  logic [$clog2(DEPTH):0] free_cnt,
    input  logic              pop_status,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word,
    output logic              commit,
    output logic              rollback,
    output logic              set_ack,
    output logic              set_done,
    output logic              set_over,
    output logic              hs_ack,
    output logic              hs_nak,
    output logic              ep_enabled,
    output logic [PCNT_W-1:0] pcnt
);
    localparam int CW = $clog2(MPS + 1);
    localparam int FW = $clog2(DEPTH) + 1;

    typedef struct packed {
        rx_state_e         st;
        logic [CW-1:0]     bcnt;
        logic              over;
        logic              en;
        logic [PCNT_W-1:0] pcnt;
        logic              ack;
        logic              nak;
    } ctl_t;

    ctl_t s_d, s_q;
    logic room_ok;

    assign room_ok = free_cnt >= FW'(MPS + 1);

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        s_d.nak  = 1'b0;
        wr_en    = 1'b0;
        wr_word  = '0;
        commit   = 1'b0;
        rollback = 1'b0;
        set_ack  = 1'b0;
        set_done = 1'b0;
        set_over = 1'b0;

        if (cfg_load) begin
            s_d.en   = 1'b1;
            s_d.pcnt = cfg_pcnt;
        end

        case (s_q.st)
            ST_IDLE: begin
                if (tok_out) begin
                    if (s_q.en && s_q.pcnt != '0 && room_ok) begin
                        s_d.st   = ST_RX;
                        s_d.bcnt = '0;
                        s_d.over = 1'b0;
                    end else begin
                        s_d.st = ST_DROP;
                    end
                end
            end
            ST_RX: begin
                if (rx_end) begin
                    s_d.st = ST_IDLE;
                    if (s_q.over) begin
                        rollback = 1'b1;
                        set_over = 1'b1;
                    end else begin
                        commit   = 1'b1;
                        set_ack  = 1'b1;
                        s_d.ack  = 1'b1;
                        s_d.pcnt = s_q.pcnt - 1'b1;
                        if (s_q.pcnt == PCNT_W'(1)) s_d.st = ST_STS;
                    end
                end else if (rx_valid) begin
                    if (s_q.bcnt == CW'(MPS)) begin
                        s_d.over = 1'b1;
                    end else begin
                        wr_en    = 1'b1;
                        wr_word  = {1'b0, rx_byte};
                        s_d.bcnt = s_q.bcnt + 1'b1;
                    end
                end
            end
            ST_DROP: begin
                if (rx_end) begin
                    s_d.nak = 1'b1;
                    s_d.st  = ST_IDLE;
                end
            end
            default: begin
                wr_en   = 1'b1;
                wr_word = {1'b1, 4'(EP_NUM), STS_XFER_DONE};
                commit  = 1'b1;
                s_d.st  = ST_IDLE;
            end
        endcase

        if (pop_status) begin
            s_d.en   = 1'b0;
            set_done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign hs_ack     = s_q.ack;
    assign hs_nak     = s_q.nak;
    assign ep_enabled = s_q.en;
    assign pcnt       = s_q.pcnt;

    AST_HS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_ack && hs_nak)); // R1
    AST_REFUSE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && tok_out && !s_q.en) |=> s_q.st == ST_DROP); // R1
    AST_ACK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ack && !cfg_load) |=> pcnt == $past(pcnt) - 1'b1); // R4
    AST_DONE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> !ep_enabled); // R6
    AST_OVERSIZE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_over && !cfg_load) |=> !hs_ack && !hs_nak && pcnt == $past(pcnt)); // R7
endmodule

// File: rtl/usb_out_ep_rx.sv
module usb_out_ep_rx
    import usbo_pkg::*;
#(
    parameter int MPS    = 4,
    parameter int DEPTH  = 16,
    parameter int EP_NUM = 1,
    parameter int PCNT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_out,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_end,
    output logic              hs_ack,
    output logic              hs_nak,
    input  logic              cfg_load,
    input  logic [PCNT_W-1:0] cfg_pcnt,
    input  logic              pop,
    output logic              rd_valid,
    output logic [8:0]        rd_word,
    input  logic [2:0]        flag_clr,
    input  logic [2:0]        irq_en,
    output logic [2:0]        flags,
    output logic              irq,
    output logic              ep_enabled,
    output logic [PCNT_W-1:0] pcnt
);
    logic              wr_en, commit, rollback;
    logic [WORD_W-1:0] wr_word;
    logic [$clog2(DEPTH):0] free_cnt;
    logic              set_ack, set_done, set_over, pop_status;

    assign pop_status = pop && rd_valid && rd_word[8];

    usbo_rx_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
        .commit(commit), .rollback(rollback), .pop(pop),
        .rd_valid(rd_valid), .rd_word(rd_word), .free_cnt(free_cnt)
    );

    usbo_ep_ctrl #(.MPS(MPS), .DEPTH(DEPTH), .EP_NUM(EP_NUM), .PCNT_W(PCNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_end(rx_end), .cfg_load(cfg_load),
        .cfg_pcnt(cfg_pcnt), .free_cnt(free_cnt), .pop_status(pop_status),
        .wr_en(wr_en), .wr_word(wr_word), .commit(commit), .rollback(rollback),
        .set_ack(set_ack), .set_done(set_done), .set_over(set_over),
        .hs_ack(hs_ack), .hs_nak(hs_nak), .ep_enabled(ep_enabled), .pcnt(pcnt)
    );

    usbo_flags #(.N(3)) u_flags (
        .clk(clk), .rst_n(rst_n), .set({set_over, set_done, set_ack}),
        .clr(flag_clr), .irq_en(irq_en), .flags(flags), .irq(irq)
    );

    AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(pop_status)); // R6
endmodule

// File: tb/tb_usb_out_ep_rx.sv
module tb_usb_out_ep_rx;
    localparam int MPS = 4, DEPTH = 16, EP_NUM = 1, PCNT_W = 6;

    logic clk = 0, rst_n = 0;
    logic tok_out = 0, rx_valid = 0, rx_end = 0, cfg_load = 0, pop = 0;
    logic [7:0] rx_byte = 0;
    logic [PCNT_W-1:0] cfg_pcnt = 0;
    logic [2:0] flag_clr = 0, irq_en = 0;
    logic hs_ack, hs_nak, rd_valid, irq, ep_enabled;
    logic [8:0] rd_word;
    logic [2:0] flags;
    logic [PCNT_W-1:0] pcnt;

    always #5 clk = ~clk;

    usb_out_ep_rx #(.MPS(MPS), .DEPTH(DEPTH), .EP_NUM(EP_NUM), .PCNT_W(PCNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .tok_out(tok_out), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .rx_end(rx_end), .hs_ack(hs_ack), .hs_nak(hs_nak),
        .cfg_load(cfg_load), .cfg_pcnt(cfg_pcnt), .pop(pop), .rd_valid(rd_valid),
        .rd_word(rd_word), .flag_clr(flag_clr), .irq_en(irq_en), .flags(flags),
        .irq(irq), .ep_enabled(ep_enabled), .pcnt(pcnt)
    );

    int errors = 0, checks = 0;
    string phase = "reset";

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s (%s): actual=%0h expected=%0h", req, what, phase, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [8:0] vis[$];
    logic [7:0] pend[$];
    int  mst = 0;
    bit  mover = 0, men = 0, mack = 0, mnak = 0;
    int  mpcnt = 0;
    logic [2:0] mflags = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            vis.delete(); pend.delete();
            mst = 0; mover = 0; men = 0; mack = 0; mnak = 0; mpcnt = 0; mflags = 0;
        end else begin
            automatic int  freew = DEPTH - (vis.size() + pend.size());
            automatic bit  oen = men;
            automatic int  opc = mpcnt;
            automatic bit  done_pop = 0;
            automatic logic [2:0] s = 0;
            if (pop && vis.size() > 0) begin
                automatic logic [8:0] w = vis.pop_front();
                done_pop = w[8];
            end
            mack = 0; mnak = 0;
            if (cfg_load) begin men = 1; mpcnt = cfg_pcnt; end
            case (mst)
                0: if (tok_out) begin
                    if (oen && opc != 0 && freew >= MPS + 1) begin
                        mst = 1; mover = 0; pend.delete();
                    end else mst = 2;
                end
                1: if (rx_end) begin
                    if (mover) begin pend.delete(); s[2] = 1; mst = 0; end
                    else begin
                        foreach (pend[i]) vis.push_back({1'b0, pend[i]});
                        pend.delete();
                        mack = 1; s[0] = 1; mpcnt = opc - 1;
                        mst = (opc == 1) ? 3 : 0;
                    end
                end else if (rx_valid) begin
                    if (pend.size() == MPS) mover = 1;
                    else pend.push_back(rx_byte);
                end
                2: if (rx_end) begin mnak = 1; mst = 0; end
                default: begin vis.push_back({1'b1, 4'(EP_NUM), 4'd3}); mst = 0; end
            endcase
            if (done_pop) begin men = 0; s[1] = 1; end
            mflags = (mflags & ~flag_clr) | s;
        end
    end

    always @(posedge clk) begin
        #2;
        chk((vis.size() > 0 && vis[0][8]) ? "R5" : "R3", "rd_valid", rd_valid, vis.size() > 0);
        if (vis.size() > 0)
            chk(vis[0][8] ? "R5" : "R3", "rd_word", rd_word, vis[0]);
        chk("R4", "hs_ack", hs_ack, mack);
        chk("R1", "hs_nak", hs_nak, mnak);
        chk("R4", "pcnt", pcnt, mpcnt);
        chk("R8", "flags", flags, mflags);
        chk("R9", "irq", irq, |(mflags & irq_en));
        chk("R6", "ep_enabled", ep_enabled, men);
    end

    task automatic packet(int n, int base);
        @(negedge clk); tok_out = 1;
        @(negedge clk); tok_out = 0;
        for (int i = 0; i < n; i++) begin
            rx_valid = 1; rx_byte = 8'(base + i);
            @(negedge clk);
        end
        rx_valid = 0; rx_end = 1;
        @(negedge clk); rx_end = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic popn(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); pop = 1;
        end
        @(negedge clk); pop = 0;
        @(negedge clk);
    endtask

    task automatic load(int p);
        @(negedge clk); cfg_load = 1; cfg_pcnt = PCNT_W'(p);
        @(negedge clk); cfg_load = 0;
    endtask

    task automatic clear(logic [2:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R8", "reset flags", flags, 0);
        chk("R6", "reset enable", ep_enabled, 0);
        chk("R3", "reset empty", rd_valid, 0);
        irq_en = 3'b111;

        phase = "disabled R1";
        packet(3, 8'h50);
        chk("R1", "no data when disabled", rd_valid, 0);

        phase = "transfer R4 R5 R6";
        load(3);
        packet(4, 8'h10);
        packet(2, 8'h20);
        packet(0, 0);
        chk("R4", "count drained", pcnt, 0);
        chk("R4", "ack flag", flags[0], 1);
        popn(6);
        chk("R5", "status at head", rd_word, 9'h113);
        chk("R6", "still enabled before status pop", ep_enabled, 1);
        chk("R6", "no done before status pop", flags[1], 0);
        popn(1);
        chk("R6", "done flag", flags[1], 1);
        chk("R6", "disabled after status pop", ep_enabled, 0);

        phase = "after completion R1";
        packet(2, 8'h30);
        chk("R1", "refused after completion", rd_valid, 0);

        phase = "clear R8 R9";
        clear(3'b111);
        chk("R8", "cleared flags", flags, 0);
        chk("R9", "irq low", irq, 0);

        phase = "space R2 R10";
        load(8);
        chk("R10", "re-enabled", ep_enabled, 1);
        packet(4, 8'h40);
        packet(4, 8'h44);
        packet(4, 8'h48);
        packet(4, 8'h4C);
        chk("R2", "refused when space short", pcnt, 5);
        popn(1);
        packet(4, 8'h60);
        chk("R2", "accepted at threshold", pcnt, 4);
        popn(15);

        phase = "oversize R7";
        packet(5, 8'h70);
        chk("R7", "oversize flag", flags[2], 1);
        chk("R7", "count unchanged", pcnt, 4);
        chk("R7", "nothing stored", rd_valid, 0);

        phase = "empty pop R11";
        popn(2);
        chk("R11", "still empty", rd_valid, 0);
        chk("R11", "flags unchanged", flags, 3'b101);

        phase = "irq mask R9";
        irq_en = 3'b100;
        clear(3'b001);
        chk("R9", "irq from oversize", irq, 1);
        clear(3'b100);
        chk("R9", "irq masked off", irq, 0);

        phase = "single R10 R5";
        load(1);
        packet(1, 8'hA5);
        chk("R3", "byte readable", rd_word, 9'h0A5);
        popn(2);
        chk("R6", "done again", flags[1], 1);
        chk("R6", "disabled again", ep_enabled, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule